// File: doc/BRIEF.md
# Redundant Fuse Program Sequencer

This block turns one logical fuse-program request, made of a word index and a 32-bit value, into a short series of raw program operations for a downstream command engine. Some index ranges are guarded by redundancy. For such an index, the value is first written to two mirror words and then to the main word, and all three writes bypass ECC. Any other legal index gets a single write with ECC enabled. Indices beyond the logical range are refused at once, and no raw operation is issued for them.

Upstream, the caller pulses `start_i` with `index_i` and `data_i`, then waits for a one-cycle `done_o`, which comes with `error_o` when the request failed. Downstream, the sequencer raises a single-cycle `raw_req_o` together with the raw index, data and ECC mode. It then waits for `raw_done_i`, sampled with `raw_error_i`, before it moves on. Only one raw operation is ever outstanding.

Top module: `fuse_prog_seq`

## Requirements
- R1: A start with `index_i` greater than 199 issues no raw request. It gives `done_o` and `error_o` high together, for one cycle, in the cycle after the start is sampled.
- R2: The protected class is indices 0..3 and 176..199. A protected index issues three raw requests. Any other index up to 199 issues exactly one.
- R3: For a protected index i below 4, the mirror positions are 200+2i and 201+2i.
- R4: For a protected index i from 176 to 199, the mirror positions are 208+2(i-176) and 209+2(i-176).
- R5: A protected index is written in a fixed order: first mirror, then second mirror, then the main word at index i. Every raw request carries the latched `data_i` on `raw_data_o`.
- R6: `raw_ecc_en_o` is 0 (bypass) on all three writes for a protected index and 1 (enabled) on the single write for an unprotected index.
- R7: When `raw_error_i` is high as `raw_done_i` is sampled, no further raw request is issued. `done_o` and `error_o` go high for one cycle in the next cycle.
- R8: `raw_req_o` is high for exactly one cycle per step. The first step's request follows an accepted start by one cycle. Each later step's request comes in the cycle after the previous `raw_done_i` is sampled.
- R9: When the last step completes without error, `done_o` is high for one cycle in the cycle after its `raw_done_i`, with `error_o` low. `error_o` is never high without `done_o`.
- R10: A start while a sequence is in progress is ignored. The running sequence's indices, data and outcome are unchanged.
- R11: After reset, `done_o`, `error_o` and `raw_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, sampled when idle |
| index_i | input | 8 | Logical fuse word index |
| data_i | input | 32 | Value to program |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Failure flag, valid with done_o |
| raw_req_o | output | 1 | One-cycle raw program request |
| raw_index_o | output | 8 | Raw word position of the request |
| raw_data_o | output | 32 | Raw data of the request |
| raw_ecc_en_o | output | 1 | 1 = ECC enabled, 0 = bypass |
| raw_done_i | input | 1 | Raw operation complete |
| raw_error_i | input | 1 | Raw operation failed, valid with raw_done_i |

## Verification
The directed cases cover both ends of each index class: 0, 3, 4, 175, 176, 199, 200 and 255. These separate the two mirror formulas and the class boundaries from their neighbours, and they separate rejection from acceptance. Injected raw errors on the first, second and third step show that an abort leaves no trailing request. A start poked mid-sequence with a different index shows that busy starts cannot disturb the latched request. Random indices, data, engine latencies and error points then mix these cases.

// File: rtl/fpseq_pkg.sv
package fpseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    STEP_MIRROR_A = 2'd0,
    STEP_MIRROR_B = 2'd1,
    STEP_MAIN     = 2'd2
  } step_e;
endpackage

// File: rtl/fpseq_classify.sv
module fpseq_classify #(
  parameter int IDX_W            = 8,
  parameter int LOGICAL_MAX      = 199,
  parameter int LOW_PROT_COUNT   = 4,
  parameter int HIGH_PROT_FIRST  = 176,
  parameter int LOW_MIRROR_BASE  = 200,
  parameter int HIGH_MIRROR_BASE = 208
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic             legal_o,
  output logic             prot_o,
  output logic [IDX_W-1:0] mirror_a_o
);
  localparam logic [IDX_W-1:0] MaxIdx   = IDX_W'(LOGICAL_MAX);
  localparam logic [IDX_W-1:0] LowEnd   = IDX_W'(LOW_PROT_COUNT);
  localparam logic [IDX_W-1:0] HighFrst = IDX_W'(HIGH_PROT_FIRST);
  localparam logic [IDX_W-1:0] LowBase  = IDX_W'(LOW_MIRROR_BASE);
  localparam logic [IDX_W-1:0] HighBase = IDX_W'(HIGH_MIRROR_BASE);

  logic             in_low;
  logic             in_high;
  logic [IDX_W-1:0] high_off;

  always_comb begin
    legal_o  = (idx_i <= MaxIdx);
    in_low   = (idx_i < LowEnd);
    in_high  = (idx_i >= HighFrst) && legal_o;
    prot_o   = in_low || in_high;
    high_off = idx_i - HighFrst;
    if (in_low) begin
      mirror_a_o = LowBase + {idx_i[IDX_W-2:0], 1'b0};
    end else begin
      mirror_a_o = HighBase + {high_off[IDX_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/fpseq_step_mux.sv
module fpseq_step_mux
  import fpseq_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  step_e            step_i,
  input  logic [IDX_W-1:0] main_idx_i,
  input  logic [IDX_W-1:0] mirror_a_i,
  output logic [IDX_W-1:0] raw_idx_o
);
  always_comb begin
    unique case (step_i)
      STEP_MIRROR_A: raw_idx_o = mirror_a_i;
      STEP_MIRROR_B: raw_idx_o = mirror_a_i + IDX_W'(1);
      default:       raw_idx_o = main_idx_i;
    endcase
  end
endmodule

// File: rtl/fpseq_ctrl.sv
module fpseq_ctrl
  import fpseq_pkg::*;
#(
  parameter int IDX_W           = 8,
  parameter int DATA_W          = 32,
  parameter int LOW_MIRROR_BASE = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  index_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              legal_i,
  input  logic              prot_i,
  input  logic [IDX_W-1:0]  mirror_a_i,
  input  logic              raw_done_i,
  input  logic              raw_error_i,
  output logic              done_o,
  output logic              error_o,
  output logic              raw_req_o,
  output logic              raw_ecc_en_o,
  output logic [DATA_W-1:0] raw_data_o,
  output step_e             step_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [IDX_W-1:0]  mirror_a_o
);
  seq_state_e        state_q, state_d;
  step_e             step_q, step_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              load_en;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  mirror_a_q;
  logic [DATA_W-1:0] data_q;
  logic              prot_q;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    load_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (!legal_i) begin
            done_d = 1'b1;
            err_d  = 1'b1;
          end else begin
            load_en = 1'b1;
            state_d = ST_ISSUE;
            step_d  = prot_i ? STEP_MIRROR_A : STEP_MAIN;
          end
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (raw_done_i) begin
          if (raw_error_i) begin
            done_d  = 1'b1;
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else if (step_q == STEP_MAIN) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            step_d  = (step_q == STEP_MIRROR_A) ? STEP_MIRROR_B : STEP_MAIN;
            state_d = ST_ISSUE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= STEP_MAIN;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      mirror_a_q <= '0;
      data_q     <= '0;
      prot_q     <= 1'b0;
    end else if (load_en) begin
      idx_q      <= index_i;
      mirror_a_q <= mirror_a_i;
      data_q     <= data_i;
      prot_q     <= prot_i;
    end
  end

  assign done_o       = done_q;
  assign error_o      = err_q;
  assign raw_req_o    = (state_q == ST_ISSUE);
  assign raw_ecc_en_o = !prot_q;
  assign raw_data_o   = data_q;
  assign step_o       = step_q;
  assign idx_o        = idx_q;
  assign mirror_a_o   = mirror_a_q;

  // R1: a refused index yields done with error next cycle, no raw request
  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i && !legal_i) |=> (done_o && error_o && !raw_req_o));

  // R6: writes to mirror space always bypass ECC
  p_mirror_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_req_o && (raw_data_o == data_q) && (step_q != STEP_MAIN)) |-> !raw_ecc_en_o);

  // R7: an engine error ends the sequence with error and no further request
  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && raw_done_i && raw_error_i) |=> (done_o && error_o && !raw_req_o));

  // R8: request is a single-cycle pulse
  p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    raw_req_o |=> !raw_req_o);

  // R8: next step follows a clean completion by one cycle
  p_next_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && raw_done_i && !raw_error_i && step_q != STEP_MAIN) |=> raw_req_o);

  // R9: done is a pulse and error only comes with it
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> done_o);

  // R10: a busy start leaves the latched request untouched
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start_i) |=> ($stable(idx_q) && $stable(data_q) && $stable(prot_q)));

  // R5: raw index stays put while waiting on the engine
  p_hold_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> $stable(step_q));

  localparam logic [IDX_W-1:0] MirrorFloor = IDX_W'(LOW_MIRROR_BASE);
  // R2: an unprotected main write never lands in mirror space
  p_main_below_mirrors_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_req_o && raw_ecc_en_o) |-> (idx_q < MirrorFloor));
endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
  import fpseq_pkg::*;
#(
  parameter int IDX_W            = 8,
  parameter int DATA_W           = 32,
  parameter int LOGICAL_MAX      = 199,
  parameter int LOW_PROT_COUNT   = 4,
  parameter int HIGH_PROT_FIRST  = 176,
  parameter int LOW_MIRROR_BASE  = 200,
  parameter int HIGH_MIRROR_BASE = 208
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  index_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              done_o,
  output logic              error_o,
  output logic              raw_req_o,
  output logic [IDX_W-1:0]  raw_index_o,
  output logic [DATA_W-1:0] raw_data_o,
  output logic              raw_ecc_en_o,
  input  logic              raw_done_i,
  input  logic              raw_error_i
);
  logic             legal;
  logic             prot;
  logic [IDX_W-1:0] mirror_a;
  step_e            step;
  logic [IDX_W-1:0] idx_lat;
  logic [IDX_W-1:0] mirror_a_lat;

  fpseq_classify #(
    .IDX_W(IDX_W), .LOGICAL_MAX(LOGICAL_MAX), .LOW_PROT_COUNT(LOW_PROT_COUNT),
    .HIGH_PROT_FIRST(HIGH_PROT_FIRST), .LOW_MIRROR_BASE(LOW_MIRROR_BASE),
    .HIGH_MIRROR_BASE(HIGH_MIRROR_BASE)
  ) u_classify (
    .idx_i(index_i), .legal_o(legal), .prot_o(prot), .mirror_a_o(mirror_a)
  );

  fpseq_ctrl #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .LOW_MIRROR_BASE(LOW_MIRROR_BASE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .index_i(index_i), .data_i(data_i),
    .legal_i(legal), .prot_i(prot), .mirror_a_i(mirror_a),
    .raw_done_i(raw_done_i), .raw_error_i(raw_error_i),
    .done_o(done_o), .error_o(error_o), .raw_req_o(raw_req_o),
    .raw_ecc_en_o(raw_ecc_en_o), .raw_data_o(raw_data_o),
    .step_o(step), .idx_o(idx_lat), .mirror_a_o(mirror_a_lat)
  );

  fpseq_step_mux #(.IDX_W(IDX_W)) u_mux (
    .step_i(step), .main_idx_i(idx_lat), .mirror_a_i(mirror_a_lat), .raw_idx_o(raw_index_o)
  );
endmodule

// File: tb/test_fuse_prog_seq.sv
module test_fuse_prog_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  index_i = '0;
  logic [31:0] data_i = '0;
  logic        done_o, error_o, raw_req_o, raw_ecc_en_o;
  logic [7:0]  raw_index_o;
  logic [31:0] raw_data_o;
  logic        raw_done_i = 1'b0;
  logic        raw_error_i = 1'b0;
  int checks = 0;
  int errors = 0;
  int wd = 0;

  always #2 clk = ~clk;

  fuse_prog_seq i_fuse_prog_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .index_i(index_i), .data_i(data_i),
    .done_o(done_o), .error_o(error_o), .raw_req_o(raw_req_o), .raw_index_o(raw_index_o),
    .raw_data_o(raw_data_o), .raw_ecc_en_o(raw_ecc_en_o),
    .raw_done_i(raw_done_i), .raw_error_i(raw_error_i)
  );

  function automatic bit is_prot(int i);
    return (i < 4) || (i >= 176 && i <= 199);
  endfunction

  function automatic int exp_pos(int i, int k, int n);
    int m;
    if (n == 1 || k == 2) return i;
    m = (i < 4) ? 200 + 2 * i : 208 + 2 * (i - 176);
    return m + k;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input int idx, input logic [31:0] dat, input int fail_at,
                        input int lat, input bit poke_busy);
    int nreq = 0;
    int cyc = 0;
    int pend = -1;
    int last_done_cyc = -10;
    int done_cyc = -1;
    bit seen_done = 1'b0;
    bit got_err = 1'b0;
    int n_exp;
    int issued_exp;
    bit err_exp;
    int r_idx[4];
    logic [31:0] r_dat[4];
    bit r_ecc[4];
    string ptag;
    n_exp = (idx > 199) ? 0 : (is_prot(idx) ? 3 : 1);
    issued_exp = (fail_at >= 0 && fail_at < n_exp) ? fail_at + 1 : n_exp;
    err_exp = (idx > 199) || (fail_at >= 0 && fail_at < n_exp);
    ptag = (idx < 4) ? "R3" : "R4";
    @(negedge clk);
    start_i = 1'b1; index_i = idx[7:0]; data_i = dat;
    @(negedge clk);
    start_i = 1'b0;
    while (!seen_done && cyc < 300) begin
      if (raw_done_i) begin raw_done_i = 1'b0; raw_error_i = 1'b0; end
      if (start_i) start_i = 1'b0;
      if (done_o) begin
        seen_done = 1'b1; got_err = error_o; done_cyc = cyc;
      end else if (raw_req_o) begin
        if (nreq < 4) begin
          r_idx[nreq] = int'(raw_index_o); r_dat[nreq] = raw_data_o; r_ecc[nreq] = raw_ecc_en_o;
        end
        if (nreq > 0)
          chk(cyc == last_done_cyc + 1, "R8", "request cycle after raw done", cyc, last_done_cyc + 1);
        else
          chk(cyc == 0, "R8", "first request cycle", cyc, 0);
        nreq++;
        pend = lat;
        if (poke_busy && nreq == 1) begin
          start_i = 1'b1; index_i = 8'd10; data_i = ~dat;
        end
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          raw_done_i = 1'b1;
          raw_error_i = (nreq - 1 == fail_at);
          last_done_cyc = cyc;
          pend = -1;
        end
      end
      if (!seen_done) begin @(negedge clk); cyc++; end
    end
    chk(seen_done, "R9", "done seen", seen_done, 1);
    chk(nreq == issued_exp, (idx > 199) ? "R1" : "R2", "raw request count", nreq, issued_exp);
    chk(got_err == err_exp, err_exp ? "R7" : "R9", "error flag", got_err, err_exp);
    if (idx > 199)
      chk(done_cyc == 0, "R1", "reject done timing", done_cyc, 0);
    else
      chk(done_cyc == last_done_cyc + 1, "R9", "done timing", done_cyc, last_done_cyc + 1);
    for (int k = 0; k < nreq && k < issued_exp && k < 4; k++) begin
      int e = exp_pos(idx, k, n_exp);
      chk(r_idx[k] == e, (k < 2 && n_exp == 3) ? ptag : "R5", "raw index", r_idx[k], e);
      chk(r_dat[k] == dat, "R5", "raw data", r_dat[k], dat);
      chk(r_ecc[k] == (n_exp == 1), "R6", "ecc mode", r_ecc[k], n_exp == 1);
    end
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      chk(!done_o && !raw_req_o, "R7", "quiet after done", {done_o, raw_req_o}, 0);
    end
  endtask

  initial begin
    for (wd = 0; wd < 150000; wd++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!done_o && !error_o && !raw_req_o, "R11", "reset outputs",
        {done_o, error_o, raw_req_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done_o && !error_o && !raw_req_o, "R11", "idle after reset",
        {done_o, error_o, raw_req_o}, 0);
    // directed class boundaries (R2, R3, R4)
    run_op(0,   32'hA5A5_0001, -1, 1, 1'b0);
    run_op(3,   32'h1234_5678, -1, 2, 1'b0);
    run_op(4,   32'hFFFF_0000, -1, 1, 1'b0);
    run_op(175, 32'h0BAD_F00D, -1, 3, 1'b0);
    run_op(176, 32'hCAFE_0176, -1, 1, 1'b0);
    run_op(199, 32'hCAFE_0199, -1, 2, 1'b0);
    // rejects (R1)
    run_op(200, 32'h1, -1, 1, 1'b0);
    run_op(255, 32'h2, -1, 1, 1'b0);
    // aborts on each step (R7)
    run_op(1,   32'h1111_1111, 0, 1, 1'b0);
    run_op(180, 32'h2222_2222, 1, 2, 1'b0);
    run_op(2,   32'h3333_3333, 2, 1, 1'b0);
    run_op(50,  32'h4444_4444, 0, 1, 1'b0);
    // busy start ignored (R10)
    run_op(190, 32'h5555_AAAA, -1, 3, 1'b1);
    run_op(77,  32'h6666_BBBB, -1, 2, 1'b1);
    // random mix
    for (int n = 0; n < 80; n++) begin
      int sel = $urandom_range(0, 3);
      int idx = (sel == 0) ? $urandom_range(0, 3) :
                (sel == 1) ? $urandom_range(170, 210) : $urandom_range(0, 255);
      int f = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 2) : -1;
      run_op(idx, $urandom, f, $urandom_range(1, 4), $urandom_range(0, 4) == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule